// File: doc/BRIEF.md
# Serial EEPROM Page-Aware Access Engine

This block drives a serial EEPROM over a four-wire SPI link (mode 0, one chip select) on behalf of a byte-array client. The client hands over one request at a time: a direction, a start offset and a byte count. Bytes to be stored are pulled from a write stream and bytes fetched are pushed out of a read stream, one byte per valid/ready beat. When the request is over, a single-cycle completion pulse reports how many bytes were moved and whether the request failed.

A read becomes one transaction: command byte, address, then every requested byte while chip select stays low. A write is cut into pieces that never cross a page boundary. Each piece is preceded by its own write-enable transaction and followed by status reads, spaced by a programmable pause, until the device reports it is no longer busy. If the device stays busy past a cycle budget and a minimum number of status reads has been made, the write stops. Requests are trimmed to the device size. With the ninth-bit option, the offset bit just above the address bytes is carried in bit 3 of the read or write command.

Top module: `eeprom_spi_ctrl`

## Requirements
- R1: After reset, req_ready is 1, spi_cs_n is 1, spi_sck is 0 and done is 0.
- R2: The link runs in SPI mode 0. SCK idles low and is low whenever chip select is high. Bytes go out most significant bit first, MOSI changes after falling edges, and MISO is sampled on rising edges.
- R3: Every transaction starts with its command byte: 0x06 enables writing, 0x03 reads, 0x02 writes and 0x05 reads status.
- R4: After a read or write command, the offset is sent as ADDR_BYTES bytes (1 to 3), most significant byte first.
- R5: With NINTH_BIT set, an offset of 2^(8*ADDR_BYTES) or more sets bit 3 (0x08) of the read or write command. The address bytes carry the low offset bits.
- R6: A read of N in-range bytes is a single chip-select assertion. It delivers N bytes on the read stream in address order and completes with done_count = N and done_err = 0.
- R7: A read starting at or past DEV_SIZE completes with count 0 and no error. A write starting there completes with count 0, done_err = 1 and no SPI traffic. A request running past the end is cut at DEV_SIZE.
- R8: A write piece holds min(PAGE_SIZE - offset mod PAGE_SIZE, bytes left) bytes. Pieces follow each other until the trimmed count is used up.
- R9: Each write piece is preceded by a separate one-byte 0x06 transaction, with chip select released in between.
- R10: After each piece, status is read until bit 0 reads 0, with POLL_GAP cycles of deselect between reads. The piece fails only once at least TIMEOUT_CYC cycles have passed since its last data byte and at least MIN_POLLS reads were made.
- R11: done is a one-cycle pulse. A write reports the bytes of all pieces that completed. done_err is 1 only if a write failed before any piece completed.
- R12: Chip select stays high for at least 2*CLK_DIV clock cycles between transactions.
- R13: A read byte stays on rd_data with rd_data_valid high until rd_data_ready accepts it. No further byte is clocked in until then.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted on valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Start byte offset |
| req_count | input | CNT_W | Requested byte count |
| wr_data_valid | input | 1 | Write byte offered |
| wr_data_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_data_valid | output | 1 | Read byte available |
| rd_data_ready | input | 1 | Read byte accepted |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request completion pulse |
| done_count | output | CNT_W | Bytes moved |
| done_err | output | 1 | Request failed with nothing moved |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The hardest cases to reach from the ports depend on the device answering busy: the timeout path, and the path where the first page succeeds and a later page times out. The bench's behavioural EEPROM model can be set to report busy forever starting from a chosen piece number. This drives both a write that fails outright and a multi-page write that stops after the first page with a non-zero count. Page splitting is observed by logging the length of every data transaction in the model and comparing it with the expected page-bounded sequence.

// File: rtl/eespi_pkg.sv
package eespi_pkg;
   localparam logic [7:0] CMD_WREN  = 8'h06;
   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] CMD_WRITE = 8'h02;
   localparam logic [7:0] CMD_STAT  = 8'h05;
   localparam logic [7:0] CMD_HIBIT = 8'h08;

   typedef enum logic [2:0] {
      S_IDLE, S_WREN, S_GAP, S_HDR, S_RDAT, S_WDAT, S_POLL, S_DONE
   } ctl_state_t;
endpackage

// File: rtl/eespi_byte_phy.sv
// Mode-0 byte shifter: one byte out on MOSI and one in from MISO per start.
module eespi_byte_phy #(
   parameter int CLK_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx,
   output logic       busy,
   output logic       fin,
   output logic [7:0] rx,
   output logic       sck,
   output logic       mosi,
   input  logic       miso
);
   localparam int DW = $clog2(CLK_DIV + 1);
   localparam logic [DW-1:0] DIV_END = DW'(CLK_DIV - 1);

   logic [DW-1:0] div;
   logic [7:0]    sh;
   logic [2:0]    nbit;

   initial begin
      assert (CLK_DIV >= 1) else $error("CLK_DIV must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         fin  <= 1'b0;
         div  <= '0;
         sh   <= '0;
         nbit <= '0;
         sck  <= 1'b0;
         rx   <= '0;
      end else begin
         fin <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            sh   <= tx;
            div  <= '0;
            nbit <= '0;
            sck  <= 1'b0;
         end else if (busy) begin
            if (div == DIV_END) begin
               div <= '0;
               sck <= ~sck;
               if (!sck) begin
                  rx <= {rx[6:0], miso};
               end else begin
                  sh   <= {sh[6:0], 1'b0};
                  nbit <= nbit + 3'd1;
                  if (nbit == 3'd7) begin
                     busy <= 1'b0;
                     fin  <= 1'b1;
                  end
               end
            end else begin
               div <= div + DW'(1);
            end
         end
      end
   end

   assign mosi = sh[7];

   p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   p_sck_low_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);
endmodule

// File: rtl/eespi_span.sv
// Range trimming, page room and ninth-bit decision for a given offset.
module eespi_span #(
   parameter int OFS_W      = 24,
   parameter int CNT_W      = 16,
   parameter int DEV_SIZE   = 8192,
   parameter int PAGE_SIZE  = 32,
   parameter int ADDR_BYTES = 2,
   parameter bit NINTH_BIT  = 1'b0
) (
   input  logic [OFS_W-1:0] ofs,
   input  logic [CNT_W-1:0] cnt,
   output logic             beyond,
   output logic [CNT_W-1:0] clip,
   output logic [CNT_W-1:0] seg,
   output logic             hi9
);
   localparam logic [31:0] DEV_L  = 32'(DEV_SIZE);
   localparam logic [31:0] PAGE_L = 32'(PAGE_SIZE);
   localparam logic [31:0] HI_L   = 32'd1 << (8 * ADDR_BYTES);

   logic [31:0] ofs32, cnt32, room_dev, room_pg;

   assign ofs32    = 32'(ofs);
   assign cnt32    = 32'(cnt);
   assign beyond   = ofs32 >= DEV_L;
   assign room_dev = beyond ? 32'd0 : DEV_L - ofs32;
   assign clip     = CNT_W'((cnt32 > room_dev) ? room_dev : cnt32);
   assign room_pg  = PAGE_L - (ofs32 & (PAGE_L - 32'd1));
   assign seg      = CNT_W'((cnt32 > room_pg) ? room_pg : cnt32);

   generate
      if (NINTH_BIT) begin : g_hi9
         assign hi9 = ofs32 >= HI_L;
      end else begin : g_no_hi9
         assign hi9 = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
   import eespi_pkg::*;
#(
   parameter int ADDR_BYTES  = 2,
   parameter bit NINTH_BIT   = 1'b0,
   parameter int DEV_SIZE    = 8192,
   parameter int PAGE_SIZE   = 32,
   parameter int OFS_W       = 24,
   parameter int CNT_W       = 16,
   parameter int CLK_DIV     = 4,
   parameter int POLL_GAP    = 50000,
   parameter int TIMEOUT_CYC = 1250000,
   parameter int MIN_POLLS   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [CNT_W-1:0] req_count,
   input  logic             wr_data_valid,
   output logic             wr_data_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_data_valid,
   input  logic             rd_data_ready,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic [CNT_W-1:0] done_count,
   output logic             done_err,
   output logic             spi_cs_n,
   output logic             spi_sck,
   output logic             spi_mosi,
   input  logic             spi_miso
);
   localparam int CS_GAP = 2 * CLK_DIV;
   localparam int GAP_MAX = (POLL_GAP > CS_GAP) ? POLL_GAP : CS_GAP;
   localparam int GW = $clog2(GAP_MAX + 1);
   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam int PW = $clog2(MIN_POLLS + 1);
   localparam logic [GW-1:0]    GAP_CS   = GW'(CS_GAP);
   localparam logic [GW-1:0]    GAP_POLL = GW'(POLL_GAP);
   localparam logic [TW-1:0]    TMO_LIM  = TW'(TIMEOUT_CYC);
   localparam logic [PW-1:0]    POLL_MIN = PW'(MIN_POLLS);
   localparam logic [PW-1:0]    POLL_PRE = PW'(MIN_POLLS - 1);
   localparam logic [1:0]       HDR_LAST = 2'(ADDR_BYTES);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   initial begin
      assert (ADDR_BYTES >= 1 && ADDR_BYTES <= 3) else $error("ADDR_BYTES out of 1..3");
      assert (PAGE_SIZE >= 1 && (PAGE_SIZE & (PAGE_SIZE - 1)) == 0) else $error("PAGE_SIZE not a power of two");
      assert (64'(DEV_SIZE) <= (64'd1 << (8 * ADDR_BYTES + int'(NINTH_BIT)))) else $error("DEV_SIZE exceeds address reach");
      assert (POLL_GAP >= CS_GAP) else $error("POLL_GAP shorter than chip-select gap");
      assert (MIN_POLLS >= 1) else $error("MIN_POLLS must be positive");
   end

   ctl_state_t       state, resume;
   logic [GW-1:0]    gap_cnt;
   logic [TW-1:0]    tmo_cnt;
   logic [PW-1:0]    polls;
   logic [1:0]       hidx;
   logic [OFS_W-1:0] ofs;
   logic [CNT_W-1:0] remain, seg_left, seg_len, committed;
   logic             is_wr, sent, rd_hold, fail;
   logic [7:0]       rd_buf;

   logic             beyond, hi9;
   logic [CNT_W-1:0] clip, seg;
   logic             go, phy_start, phy_busy, phy_fin;
   logic [7:0]       tx_byte, phy_rx, cmd, hdr_byte;

   eespi_span #(
      .OFS_W(OFS_W), .CNT_W(CNT_W), .DEV_SIZE(DEV_SIZE), .PAGE_SIZE(PAGE_SIZE),
      .ADDR_BYTES(ADDR_BYTES), .NINTH_BIT(NINTH_BIT)
   ) u_span (
      .ofs   ((state == S_IDLE) ? req_offset : ofs),
      .cnt   ((state == S_IDLE) ? req_count  : remain),
      .beyond(beyond),
      .clip  (clip),
      .seg   (seg),
      .hi9   (hi9)
   );

   eespi_byte_phy #(.CLK_DIV(CLK_DIV)) u_phy (
      .clk  (clk),
      .rst_n(rst_n),
      .start(phy_start),
      .tx   (tx_byte),
      .busy (phy_busy),
      .fin  (phy_fin),
      .rx   (phy_rx),
      .sck  (spi_sck),
      .mosi (spi_mosi),
      .miso (spi_miso)
   );

   always_comb begin
      cmd = (is_wr ? CMD_WRITE : CMD_READ) | (hi9 ? CMD_HIBIT : 8'h00);
      if (hidx == 2'd0) hdr_byte = cmd;
      else              hdr_byte = 8'(ofs >> (8 * (ADDR_BYTES - int'(hidx))));
   end

   always_comb begin
      tx_byte = 8'h00;
      go      = 1'b0;
      case (state)
         S_WREN: begin tx_byte = CMD_WREN; go = !sent; end
         S_HDR:  begin tx_byte = hdr_byte; go = !sent; end
         S_RDAT: go = !sent && !rd_hold && (remain != '0);
         S_WDAT: begin tx_byte = wr_data; go = !sent && wr_data_valid && (seg_left != '0); end
         S_POLL: begin tx_byte = (hidx == 2'd0) ? CMD_STAT : 8'h00; go = !sent; end
         default: ;
      endcase
   end

   assign phy_start     = go && !phy_busy;
   assign req_ready     = (state == S_IDLE);
   assign wr_data_ready = (state == S_WDAT) && !sent && !phy_busy && (seg_left != '0);
   assign rd_data_valid = rd_hold;
   assign rd_data       = rd_buf;
   assign spi_cs_n      = !(state inside {S_WREN, S_HDR, S_RDAT, S_WDAT, S_POLL});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;  resume <= S_IDLE;  gap_cnt <= '0;  tmo_cnt <= '0;
         polls <= '0;  hidx <= '0;  ofs <= '0;  remain <= '0;  seg_left <= '0;
         seg_len <= '0;  committed <= '0;  is_wr <= 1'b0;  sent <= 1'b0;
         rd_hold <= 1'b0;  fail <= 1'b0;  rd_buf <= '0;
         done <= 1'b0;  done_count <= '0;  done_err <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tmo_cnt != TMO_LIM) tmo_cnt <= tmo_cnt + TW'(1);
         if (phy_start)    sent <= 1'b1;
         else if (phy_fin) sent <= 1'b0;
         case (state)
            S_IDLE: if (req_valid) begin
               is_wr <= req_write;  ofs <= req_offset;  committed <= '0;
               fail <= 1'b0;  hidx <= '0;
               if (beyond || clip == '0) begin
                  fail  <= req_write && beyond;
                  state <= S_DONE;
               end else begin
                  remain <= clip;
                  state  <= req_write ? S_WREN : S_HDR;
               end
            end
            S_WREN: if (phy_fin) begin
               hidx <= '0;  resume <= S_HDR;  gap_cnt <= GAP_CS;  state <= S_GAP;
            end
            S_GAP: begin
               if (gap_cnt <= GW'(1)) state <= resume;
               else gap_cnt <= gap_cnt - GW'(1);
            end
            S_HDR: if (phy_fin) begin
               if (hidx == HDR_LAST) begin
                  hidx <= '0;
                  if (is_wr) begin
                     seg_left <= seg;  seg_len <= seg;  state <= S_WDAT;
                  end else begin
                     state <= S_RDAT;
                  end
               end else begin
                  hidx <= hidx + 2'd1;
               end
            end
            S_RDAT: begin
               if (phy_fin) begin
                  rd_buf <= phy_rx;  rd_hold <= 1'b1;
                  remain <= remain - ONE;  committed <= committed + ONE;
               end
               if (rd_hold && rd_data_ready) rd_hold <= 1'b0;
               if (remain == '0 && !rd_hold && !sent) begin
                  resume <= S_DONE;  gap_cnt <= GAP_CS;  state <= S_GAP;
               end
            end
            S_WDAT: if (phy_fin) begin
               ofs <= ofs + OFS_W'(1);  remain <= remain - ONE;  seg_left <= seg_left - ONE;
               if (seg_left == ONE) begin
                  tmo_cnt <= '0;  polls <= '0;  hidx <= '0;
                  resume <= S_POLL;  gap_cnt <= GAP_CS;  state <= S_GAP;
               end
            end
            S_POLL: if (phy_fin) begin
               if (hidx == 2'd0) begin
                  hidx <= 2'd1;
               end else begin
                  hidx <= '0;
                  state <= S_GAP;
                  gap_cnt <= GAP_CS;
                  if (polls != POLL_MIN) polls <= polls + PW'(1);
                  if (!phy_rx[0]) begin
                     committed <= committed + seg_len;
                     resume <= (remain == '0) ? S_DONE : S_WREN;
                  end else if (tmo_cnt >= TMO_LIM && polls >= POLL_PRE) begin
                     fail   <= 1'b1;
                     resume <= S_DONE;
                  end else begin
                     resume  <= S_POLL;
                     gap_cnt <= GAP_POLL;
                  end
               end
            end
            S_DONE: begin
               done       <= 1'b1;
               done_count <= committed;
               done_err   <= fail && (committed == '0);
               state      <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_cs_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |=> spi_cs_n);
   p_sck_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);
   p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_valid && !rd_data_ready) |=> (rd_data_valid && $stable(rd_data)));
   p_count_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(done_count) <= 32'(DEV_SIZE)));
   p_fail_polls_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fail) && state == S_GAP) |-> (polls >= POLL_MIN && tmo_cnt >= TMO_LIM));
endmodule

// File: tb/eeprom_spi_ctrl_bench.sv
module eeprom_spi_ctrl_bench;
   localparam int TCLK = 10;
   localparam int ABYTES = 1, DSIZE = 512, PSIZE = 8, OW = 16, CW = 10, DIV = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready, req_write = 1'b0;
   logic [OW-1:0] req_offset = '0;
   logic [CW-1:0] req_count = '0;
   logic wr_data_valid = 1'b0, wr_data_ready;
   logic [7:0] wr_data = 8'h00;
   logic rd_data_valid, rd_data_ready = 1'b1;
   logic [7:0] rd_data;
   logic done, done_err;
   logic [CW-1:0] done_count;
   logic spi_cs_n, spi_sck, spi_mosi;
   logic spi_miso = 1'b0;

   always #(TCLK/2) clk = ~clk;

   eeprom_spi_ctrl #(
      .ADDR_BYTES(ABYTES), .NINTH_BIT(1'b1), .DEV_SIZE(DSIZE), .PAGE_SIZE(PSIZE),
      .OFS_W(OW), .CNT_W(CW), .CLK_DIV(DIV), .POLL_GAP(8), .TIMEOUT_CYC(600), .MIN_POLLS(4)
   ) u_eeprom_spi_ctrl (.*);

   int checks = 0, errors = 0;
   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- behavioural EEPROM ----------------
   logic [7:0] mem [0:DSIZE-1];
   logic [7:0] expm [0:DSIZE-1];
   logic [7:0] m_in = 0, m_op = 0, m_nxt = 0, m_sh = 0;
   int m_bit = 0, m_cnt = 0, m_addr = 0, m_seg = 0, m_busy = 0;
   bit m_wel = 0, m_stuck = 0, saw9 = 0;
   int wren_n = 0, poll_n = 0, wseg_n = 0, rd_n = 0, bad_op = 0, stuck_from = 1000000;
   int segs [0:63];

   function automatic bit is_rd(input logic [7:0] op); return (op & 8'hF7) == 8'h03; endfunction
   function automatic bit is_wrop(input logic [7:0] op); return (op & 8'hF7) == 8'h02; endfunction

   always @(negedge spi_cs_n) begin m_bit = 0; m_cnt = 0; m_nxt = 0; end
   always @(posedge spi_cs_n) begin
      if (is_wrop(m_op) && m_cnt > 1 && m_wel) begin
         if (wseg_n < 64) segs[wseg_n] = m_seg;
         wseg_n++;
         m_busy = 2;
         if (wseg_n >= stuck_from) m_stuck = 1;
      end
      if (is_wrop(m_op)) m_wel = 0;
      m_op = 8'h00;
   end
   always @(posedge spi_sck) if (!spi_cs_n) begin
      m_in = {m_in[6:0], spi_mosi};
      m_bit++;
      if (m_bit == 8) begin
         m_bit = 0;
         if (m_cnt == 0) begin
            m_op = m_in;
            if (m_in == 8'h06) begin m_wel = 1; wren_n++; end
            else if (m_in == 8'h05) begin
               poll_n++;
               m_nxt = {7'd0, (m_stuck || m_busy > 0)};
               if (m_busy > 0) m_busy--;
            end else if (is_rd(m_in) || is_wrop(m_in)) begin
               m_addr = m_in[3] ? 256 : 0;
               if (m_in[3]) saw9 = 1;
               if (is_rd(m_in)) rd_n++;
               m_seg = 0;
            end else bad_op++;
         end else if (m_cnt == 1 && (is_rd(m_op) || is_wrop(m_op))) begin
            m_addr = m_addr | int'(m_in);
            if (is_rd(m_op)) m_nxt = mem[m_addr];
         end else if (is_rd(m_op)) begin
            m_addr = (m_addr + 1) % DSIZE;
            m_nxt = mem[m_addr];
         end else if (is_wrop(m_op)) begin
            if (m_wel) mem[m_addr] = m_in;
            m_addr = (m_addr & ~(PSIZE - 1)) | ((m_addr + 1) & (PSIZE - 1));
            m_seg++;
         end
         m_cnt++;
      end
   end
   always @(negedge spi_sck) if (!spi_cs_n) begin
      if (m_bit == 0) m_sh = m_nxt;
      spi_miso = m_sh[7];
      m_sh = m_sh << 1;
   end

   // ---------------- stream drivers (negedge) ----------------
   logic [7:0] wbuf [0:63];
   logic [7:0] rbuf [0:63];
   int widx = 0, ridx = 0, stall = 0, stall_seen = 0, stable_bad = 0;
   bit w_pend = 0, prev_stalled = 0;
   logic [7:0] prev_rd = 0;
   int hi_run = 0, gap_bad = 0;
   bit had_tx = 0;

   always @(negedge clk) begin
      if (w_pend) widx = widx + 1;
      wr_data = wbuf[widx % 64];
      w_pend = wr_data_valid && wr_data_ready;
      rd_data_ready = (stall == 0);
      if (stall > 0) stall--;
      if (rd_data_valid && !rd_data_ready) begin
         stall_seen++;
         if (prev_stalled && rd_data != prev_rd) stable_bad++;
         prev_stalled = 1; prev_rd = rd_data;
      end else prev_stalled = 0;
      if (rd_data_valid && rd_data_ready) begin rbuf[ridx % 64] = rd_data; ridx++; end
      if (spi_cs_n) hi_run++;
      else begin
         if (had_tx && hi_run > 0 && hi_run < 2 * DIV) gap_bad++;
         had_tx = 1; hi_run = 0;
      end
   end

   int got_cnt; bit got_err;
   task automatic do_req(input bit wr, input int ofs, input int cnt);
      @(negedge clk);
      widx = 0; ridx = 0; w_pend = 0;
      wr_data_valid = wr;
      req_valid = 1; req_write = wr; req_offset = OW'(ofs); req_count = CW'(cnt);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 0;
      while (!done) @(negedge clk);
      got_cnt = int'(done_count); got_err = done_err;
      wr_data_valid = 0;
      @(negedge clk);
   endtask

   task automatic write_bytes(input int ofs, input int cnt, input int seed);
      for (int i = 0; i < cnt; i++) wbuf[i] = 8'((seed * 7 + i * 13) ^ 8'hC3);
      do_req(1, ofs, cnt);
      for (int i = 0; i < cnt && ofs + i < DSIZE; i++) expm[ofs + i] = wbuf[i];
   endtask

   task automatic read_cmp(input int ofs, input int cnt, input int exp_cnt, input string req);
      int bad;
      bad = 0;
      do_req(0, ofs, cnt);
      chk(got_cnt == exp_cnt && !got_err, req, got_cnt, exp_cnt);
      for (int i = 0; i < exp_cnt; i++) if (rbuf[i] != expm[ofs + i]) bad++;
      chk(bad == 0 && ridx == exp_cnt, {req, " data"}, bad, 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset;
      chk(req_ready && spi_cs_n && !spi_sck && !done, "R1 reset state",
          int'({req_ready, spi_cs_n, spi_sck, done}), 4'b1100);
   endtask

   task automatic t_simple_write_read;
      int w0, r0;
      w0 = wren_n; r0 = rd_n;
      write_bytes(3, 5, 1);
      chk(got_cnt == 5 && !got_err, "R11 simple write count", got_cnt, 5);
      chk(wren_n - w0 == 1, "R9 one enable for one piece", wren_n - w0, 1);
      read_cmp(3, 5, 5, "R2 R4 R6 read back");
      chk(rd_n - r0 == 1, "R6 single read transaction", rd_n - r0, 1);
      chk(bad_op == 0, "R3 command bytes recognised", bad_op, 0);
   endtask

   task automatic t_split;
      int w0, s0, p0, bad;
      w0 = wren_n; s0 = wseg_n; p0 = poll_n; bad = 0;
      write_bytes(5, 20, 2);
      chk(got_cnt == 20 && !got_err, "R8 split write count", got_cnt, 20);
      chk(wseg_n - s0 == 4, "R8 piece count", wseg_n - s0, 4);
      if (segs[s0] != 3) bad++;
      if (segs[s0 + 1] != 8) bad++;
      if (segs[s0 + 2] != 8) bad++;
      if (segs[s0 + 3] != 1) bad++;
      chk(bad == 0, "R8 piece lengths 3,8,8,1", bad, 0);
      chk(wren_n - w0 == 4, "R9 enable per piece", wren_n - w0, 4);
      chk(poll_n - p0 == 12, "R10 polls until ready", poll_n - p0, 12);
      read_cmp(5, 20, 20, "R6 split read back");
   endtask

   task automatic t_ninth;
      saw9 = 0;
      write_bytes(300, 4, 3);
      chk(saw9 && got_cnt == 4, "R5 high bit in command", int'(saw9), 1);
      read_cmp(300, 4, 4, "R5 high read back");
      read_cmp(44, 4, 4, "R5 low alias untouched");
   endtask

   task automatic t_clip;
      int w0;
      read_cmp(508, 10, 4, "R7 read cut at end");
      do_req(0, 512, 3);
      chk(got_cnt == 0 && !got_err, "R7 read past end", got_cnt + 100 * int'(got_err), 0);
      w0 = wren_n;
      do_req(1, 600, 2);
      chk(got_cnt == 0 && got_err && wren_n == w0, "R7 write past end", got_cnt + 100 * int'(got_err), 100);
      write_bytes(510, 5, 4);
      chk(got_cnt == 2 && !got_err, "R7 write cut at end", got_cnt, 2);
   endtask

   task automatic t_timeout;
      int p0;
      p0 = poll_n;
      stuck_from = wseg_n + 1;
      write_bytes(40, 3, 5);
      chk(got_cnt == 0 && got_err, "R10 R11 timeout error", got_cnt + 100 * int'(got_err), 100);
      chk(poll_n - p0 >= 4, "R10 minimum polls", poll_n - p0, 4);
      m_stuck = 0; m_busy = 0; stuck_from = 1000000;
   endtask

   task automatic t_partial;
      stuck_from = wseg_n + 2;
      write_bytes(16, 12, 6);
      chk(got_cnt == 8 && !got_err, "R11 partial commit", got_cnt + 100 * int'(got_err), 8);
      m_stuck = 0; m_busy = 0; stuck_from = 1000000;
   endtask

   task automatic t_backpressure;
      stall_seen = 0; stable_bad = 0;
      stall = 120;
      read_cmp(8, 6, 6, "R13 read under stall");
      chk(stall_seen > 10 && stable_bad == 0, "R13 held byte stable", stable_bad, 0);
   endtask

   initial begin
      for (int i = 0; i < DSIZE; i++) begin mem[i] = 8'(i) ^ 8'h5A; expm[i] = 8'(i) ^ 8'h5A; end
      for (int i = 0; i < 64; i++) wbuf[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_simple_write_read();
      t_split();
      t_ninth();
      t_clip();
      t_timeout();
      t_partial();
      t_backpressure();
      chk(gap_bad == 0, "R12 deselect gap", gap_bad, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule